// File: doc/BRIEF.md
# Two-Wire Bus Condition Watcher

This block listens to the data and clock lines of an open-drain two-wire serial bus (such as I2C) and reports the bus-level framing events. Each line first passes through a two-flop synchroniser and a three-sample majority filter. An edge classifier then flags a data-line fall or rise that happens while the clock line stays high. A fall is a start condition and a rise is a stop condition. The block never drives either line, and it does not decode bytes or addresses.

A small state machine tracks the bus session. It has three states: `ST_IDLE` (bus free), `ST_BUSY` (a session is open) and `ST_HOLDOFF` (a stop was seen and the bus-free gap is counting down). The transitions are named as follows:

- `ST_IDLE` to `ST_BUSY` on a start (fresh start).
- `ST_BUSY` to `ST_BUSY` on a start (repeated start).
- `ST_BUSY` to `ST_HOLDOFF` on a stop, which loads the gap counter.
- `ST_HOLDOFF` to `ST_BUSY` on a start, which cancels the gap.
- `ST_HOLDOFF` to `ST_HOLDOFF` on a stop, which reloads the gap counter.
- `ST_HOLDOFF` to `ST_IDLE` when the gap counter reaches zero.

Within `ST_HOLDOFF`, a start takes priority over gap expiry.

The outputs are one-cycle pulses for a fresh start, a repeated start and a stop, plus a bus-busy level. The gap length comes from a configuration input, given in system clock cycles.

Top module: `twi_bus_watch`

## Requirements
- R1: After reset, `busy_o` is 0, no pulse output is high, and both filtered lines are taken as high.
- R2: A data-line fall while the clock line is high, seen when no session is open, gives a one-cycle `start_o` pulse and sets `busy_o` to 1.
- R3: A data-line fall while the clock line is high, seen while a session is open, gives a one-cycle `rstart_o` pulse and no `start_o` pulse, and `busy_o` stays 1.
- R4: A data-line rise while the clock line is high gives a one-cycle `stop_o` pulse in any state. A stop seen while the bus is free leaves `busy_o` at 0.
- R5: Data-line changes made while the clock line is low, and clock-line edges, give no pulse and leave `busy_o` unchanged.
- R6: After a stop that ends a session, `busy_o` stays 1 and then falls exactly `free_cycles_i`+1 system cycles after the `stop_o` pulse rises. `free_cycles_i` is sampled in the cycle the stop is detected.
- R7: A start during the bus-free countdown gives `start_o` (not `rstart_o`), cancels the countdown and keeps `busy_o` at 1 without a gap. This holds even when the start lands in the cycle the countdown expires.
- R8: A level on either line that lasts a single system cycle is rejected by the majority filter and gives no pulse.
- R9: At most one of `start_o`, `rstart_o` and `stop_o` is high in any cycle, and none stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_i | input | 1 | Sampled data-line level |
| scl_i | input | 1 | Sampled clock-line level |
| free_cycles_i | input | FREE_W | Bus-free gap length in system cycles |
| start_o | output | 1 | Fresh start pulse |
| rstart_o | output | 1 | Repeated start pulse |
| stop_o | output | 1 | Stop pulse |
| busy_o | output | 1 | Bus busy level |

## Verification
Two events can land in the same cycle: expiry of the bus-free countdown and the detection of a new start. In that case the start must win, with no one-cycle drop of `busy_o`, and it must still be reported as a fresh start. The bench provokes this by sweeping the delay between a stop and the next start across a window that spans the countdown end, one cycle at a time. In every step the scoreboard expects a stop followed by a fresh start, and `busy_o` is checked high after the start. Whenever `busy_o` does fall, the number of cycles since the last stop pulse is compared with the programmed gap.

// File: rtl/twi_watch_pkg.sv
package twi_watch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BUSY    = 2'd1,
        ST_HOLDOFF = 2'd2
    } watch_state_e;

    localparam int LINE_SDA = 0;
    localparam int LINE_SCL = 1;
    localparam int N_LINES  = 2;

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int WIN         = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW   = $clog2(WIN + 1);
    localparam int HALF = WIN / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [WIN-1:0]         win_q;
    logic [CW-1:0]          ones;
    logic                   line_q;

    // metastability guard, idle bus level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // sliding sample window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < WIN; i++) begin
            ones = ones + CW'(win_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= (ones > CW'(HALF));
    end

    assign line_o = line_q;

endmodule

// File: rtl/twi_edge_classify.sv
module twi_edge_classify (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_f,
    input  logic scl_f,
    output logic start_evt,
    output logic stop_evt
);
    logic sda_q;
    logic scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_f;
            scl_q <= scl_f;
        end
    end

    // data edge with the clock held high on both samples
    always_comb begin
        start_evt = scl_q & scl_f & sda_q & ~sda_f;
        stop_evt  = scl_q & scl_f & ~sda_q & sda_f;
    end

endmodule

// File: rtl/twi_gap_timer.sv
module twi_gap_timer #(
    parameter int FREE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [FREE_W-1:0] load_val,
    output logic              expired
);
    logic [FREE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/twi_bus_watch.sv
module twi_bus_watch
    import twi_watch_pkg::*;
#(
    parameter int FREE_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAJ_WIN     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_i,
    input  logic [FREE_W-1:0] free_cycles_i,
    output logic              start_o,
    output logic              rstart_o,
    output logic              stop_o,
    output logic              busy_o
);
    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] flt_lines;
    logic               start_evt;
    logic               stop_evt;
    logic               gap_done;
    watch_state_e       state_q;
    watch_state_e       state_d;

    assign raw_lines[LINE_SDA] = sda_i;
    assign raw_lines[LINE_SCL] = scl_i;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        twi_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .WIN         (MAJ_WIN)
        ) i_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (flt_lines[g])
        );
    end

    twi_edge_classify i_classify (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_f     (flt_lines[LINE_SDA]),
        .scl_f     (flt_lines[LINE_SCL]),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    twi_gap_timer #(
        .FREE_W (FREE_W)
    ) i_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (stop_evt),
        .run      (state_q == ST_HOLDOFF),
        .load_val (free_cycles_i),
        .expired  (gap_done)
    );

    // next-state logic; start outranks gap expiry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_evt) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (stop_evt) state_d = ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
                if (start_evt)     state_d = ST_BUSY;
                else if (stop_evt) state_d = ST_HOLDOFF;
                else if (gap_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o  <= 1'b0;
            rstart_o <= 1'b0;
            stop_o   <= 1'b0;
            busy_o   <= 1'b0;
        end else begin
            start_o  <= start_evt && (state_q != ST_BUSY);
            rstart_o <= start_evt && (state_q == ST_BUSY);
            stop_o   <= stop_evt;
            busy_o   <= (state_d != ST_IDLE);
        end
    end

endmodule

// File: rtl/twi_bus_watch_chk.sv
module twi_bus_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic start_o,
    input logic rstart_o,
    input logic stop_o,
    input logic busy_o
);
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, rstart_o, stop_o}));

    p_stop_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);

    p_rstart_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_o |-> (busy_o && $past(busy_o)));

    p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> start_o);

    p_stop_keeps_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && $past(busy_o)) |-> busy_o);

    p_no_drop_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !(start_o || rstart_o || stop_o));

endmodule

bind twi_bus_watch twi_bus_watch_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_o  (start_o),
    .rstart_o (rstart_o),
    .stop_o   (stop_o),
    .busy_o   (busy_o)
);

// File: tb/test_twi_bus_watch.sv
module test_twi_bus_watch;
    localparam int FW   = 16;
    localparam int HOLD = 8;
    localparam int EV_START  = 0;
    localparam int EV_RSTART = 1;
    localparam int EV_STOP   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sda = 1'b1;
    logic          scl = 1'b1;
    logic [FW-1:0] free_cfg = 16'd40;
    logic          start_o, rstart_o, stop_o, busy_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    int cyc = 0;
    int stop_cyc = 0;
    int exp_q[$];
    logic prev_busy = 1'b0;
    logic prev_pulse = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;

    twi_bus_watch #(.FREE_W(FW)) i_twi_bus_watch (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_i         (sda),
        .scl_i         (scl),
        .free_cycles_i (free_cfg),
        .start_o       (start_o),
        .rstart_o      (rstart_o),
        .stop_o        (stop_o),
        .busy_o        (busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(input int ev);
        exp_q.push_back(ev);
    endtask

    task automatic bus(input logic d, input logic c);
        @(negedge clk);
        sda = d;
        scl = c;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic do_start();
        bus(1, 1); push(EV_START); bus(0, 1); bus(0, 0);
    endtask

    task automatic do_rstart();
        bus(1, 0); bus(1, 1); push(EV_RSTART); bus(0, 1); bus(0, 0);
    endtask

    task automatic do_stop();
        bus(0, 0); bus(0, 1); push(EV_STOP); bus(1, 1);
    endtask

    task automatic send_bit(input logic b);
        bus(b, 0); bus(b, 1); bus(b, 0);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected events, measures the bus-free gap
    always @(negedge clk) begin
        if (rst_n) begin
            int cnt;
            int code;
            cnt = int'(start_o) + int'(rstart_o) + int'(stop_o);
            check(cnt <= 1, "R9 exclusive pulses", cnt, 1);
            if (cnt == 1) begin
                check(!prev_pulse, "R9 pulse width", 2, 1);
                code = start_o ? EV_START : (rstart_o ? EV_RSTART : EV_STOP);
                n_pulse++;
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected pulse", code, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(code == e, (e == EV_RSTART) ? "R3 event kind" :
                                     (e == EV_STOP) ? "R4 event kind" : "R2 event kind", code, e);
                end
                if (stop_o) stop_cyc = cyc;
            end
            if (prev_busy && !busy_o)
                check((cyc - stop_cyc) == int'(free_cfg) + 1, "R6 gap length",
                      cyc - stop_cyc, int'(free_cfg) + 1);
            prev_busy  = busy_o;
            prev_pulse = (cnt != 0);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        check(busy_o == 0, "R1 busy in reset", busy_o, 0);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        check(busy_o == 0, "R1 busy after reset", busy_o, 0);
        check(n_pulse == 0, "R1 no pulse after reset", n_pulse, 0);

        // session with data bits, repeated start, stop
        do_start();
        check(busy_o == 1, "R2 busy after start", busy_o, 1);
        base = n_pulse;
        send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        check(n_pulse == base, "R5 data bits silent", n_pulse, base);
        check(busy_o == 1, "R5 busy kept", busy_o, 1);
        do_rstart();
        check(busy_o == 1, "R3 busy kept", busy_o, 1);
        send_bit(0);
        do_stop();
        check(busy_o == 1, "R6 busy during gap", busy_o, 1);
        repeat (60) @(negedge clk);
        check(busy_o == 0, "R6 busy released", busy_o, 0);

        // start during hold-off
        do_start();
        do_stop();
        push(EV_START); bus(0, 1); bus(0, 0);
        check(busy_o == 1, "R7 busy after holdoff start", busy_o, 1);
        do_stop();
        repeat (60) @(negedge clk);
        check(busy_o == 0, "R6 busy released 2", busy_o, 0);

        // stray stop while free
        bus(1, 0); bus(0, 0); bus(0, 1); push(EV_STOP); bus(1, 1);
        repeat (10) @(negedge clk);
        check(busy_o == 0, "R4 stray stop no busy", busy_o, 0);

        // glitch rejection while free and inside a session
        base = n_pulse;
        @(negedge clk); sda = 0; @(negedge clk); sda = 1;
        repeat (12) @(negedge clk);
        check(n_pulse == base, "R8 sda glitch idle", n_pulse, base);
        check(busy_o == 0, "R8 busy idle", busy_o, 0);
        do_start();
        bus(0, 0); bus(0, 1);
        base = n_pulse;
        @(negedge clk); sda = 1; @(negedge clk); sda = 0;
        repeat (12) @(negedge clk);
        check(n_pulse == base, "R8 sda glitch busy", n_pulse, base);
        @(negedge clk); scl = 0; @(negedge clk); scl = 1;
        repeat (12) @(negedge clk);
        check(n_pulse == base, "R8 scl glitch busy", n_pulse, base);
        check(busy_o == 1, "R8 busy kept", busy_o, 1);
        push(EV_STOP); bus(1, 1);
        repeat (60) @(negedge clk);

        // sweep a start across the end of the countdown
        free_cfg = 16'd12;
        for (int k = 0; k < 22; k++) begin
            do_start();
            do_stop();
            repeat (k) @(negedge clk);
            push(EV_START); bus(0, 1); bus(0, 0);
            check(busy_o == 1, "R7 sweep busy", busy_o, 1);
            do_stop();
            repeat (30) @(negedge clk);
        end

        // zero gap
        free_cfg = 16'd0;
        do_start();
        do_stop();
        repeat (10) @(negedge clk);
        check(busy_o == 0, "R6 zero gap", busy_o, 0);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R9 all events seen", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule